// File: doc/BRIEF.md
# Interleaved Dual-Sequencer Command Issuer

This block feeds an elliptic-curve field-arithmetic datapath with one command word per clock cycle. Two small program sequencers each own an instruction memory that holds half of the point-operation program. Each sequencer is allowed to act only on every second cycle, and the two are offset by one cycle. Their outputs are merged onto a single registered command bus. The downstream decoder therefore sees a fixed, predictable issue rate and needs no handshake back to the issuer.

A host loads both instruction memories through an init port while the block is idle. It then launches a complete scalar multiplication with one start pulse. From that point every addition and doubling command comes from the local sequencers. The block raises `done` once both sequencers have reached their end instruction. To change the algorithm, or to insert dummy operations, the host only rewrites memory contents. A single-sequencer mode runs program A alone at one command every two cycles, which gives a baseline for comparison.

Each instruction word is `CMD_W+2` bits wide. Its top two bits are the opcode: 00 means issue, 01 means wait, 10 means end, and 11 is treated as issue. The low `CMD_W` bits are the command payload.

Top module: `fa_cmd_issuer`

## Requirements
- R1: While reset is held, and after it is released with no start, `cmd_valid` and `done` are 0.
- R2: In dual mode a start sampled at edge e0 makes `cmd_valid` rise after edge e0+1. Slots then alternate A, B, A, B, one per cycle, and issue instructions give commands on consecutive cycles.
- R3: With issue-only programs of equal length, the k-th command (counting from 0) carries the payload of A[k/2] when k is even and of B[(k-1)/2] when k is odd. Addresses start at 0 and count up by one per consumed instruction.
- R4: A wait instruction in the active slot while `dp_busy` is 1 freezes both sequencers and the phase, and `cmd_valid` stays 0. When the slot sees `dp_busy` at 0, the wait is consumed as one idle cycle and alternation resumes with the other sequencer.
- R5: A sequencer that reaches an end instruction stops, and its later slots are idle cycles. When the second sequencer stops (in single mode, when A stops), `done` is 1 after that edge and `cmd_valid` is 0.
- R6: `done` holds at 1 until the next accepted start. It is 0 after the edge that samples that start.
- R7: `single_mode` is sampled with start. In single mode only memory A is executed, at one command per two cycles, and memory B has no effect on the output.
- R8: A start that arrives while a run is in progress is ignored, and the command stream continues unchanged.
- R9: Init writes take effect only while no run is in progress. A write issued during a run leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| init_we | input | 1 | Instruction memory write strobe |
| init_sel | input | 1 | Memory select: 0 = sequencer A, 1 = sequencer B |
| init_addr | input | IMEM_AW | Write address |
| init_data | input | CMD_W+2 | Instruction word (opcode in top two bits) |
| start | input | 1 | Start a scalar multiplication |
| single_mode | input | 1 | Run sequencer A alone (sampled with start) |
| dp_busy | input | 1 | Datapath busy flag, checked by wait instructions |
| cmd_valid | output | 1 | Command strobe |
| cmd_word | output | CMD_W | Command payload |
| done | output | 1 | Program finished, held until next start |

## Verification
Every result comes from one register stage that follows the slot decision. A command or an idle slot decided in the cycle after edge n therefore shows up on the ports after edge n+1. The first command follows one cycle after the start edge, and `done` follows the edge that processes the last end instruction. The bench reference model advances its own state at each rising edge with the same inputs the design samples. The bench then compares `cmd_valid`, `cmd_word` and `done` at the following falling edge, so every expectation lines up with that single stage. Directed checks repeat this count for the first-command latency, the stall window, command spacing and the clearing of `done`.

// File: rtl/fa_seq_pkg.sv
package fa_seq_pkg;

  typedef enum logic [1:0] {
    OP_ISSUE = 2'b00,
    OP_WAIT  = 2'b01,
    OP_END   = 2'b10,
    OP_ALT   = 2'b11
  } seq_op_e;

  function automatic seq_op_e op_of(input logic [1:0] bits);
    return seq_op_e'(bits);
  endfunction

  function automatic logic op_emits(input seq_op_e op);
    return (op == OP_ISSUE) || (op == OP_ALT);
  endfunction

endpackage

// File: rtl/fa_seq_imem.sv
module fa_seq_imem #(
  parameter int AW = 5,
  parameter int IW = 18
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/fa_seq_engine.sv
module fa_seq_engine
  import fa_seq_pkg::*;
#(
  parameter int AW = 5,
  parameter int IW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          slot,
  input  logic          dp_busy,
  input  logic [IW-1:0] instr,
  output logic [AW-1:0] pc,
  output logic          halted,
  output logic          issue,
  output logic          stall,
  output logic          end_hit
);
  seq_op_e       op;
  logic          active;
  logic          step;
  logic          en;
  logic [AW-1:0] pc_d;
  logic          halt_d;

  assign op      = op_of(instr[IW-1 -: 2]);
  assign active  = slot && !halted;
  assign issue   = active && op_emits(op);
  assign stall   = active && (op == OP_WAIT) && dp_busy;
  assign end_hit = active && (op == OP_END);
  assign step    = issue || (active && (op == OP_WAIT) && !dp_busy);
  assign en      = clear || step || end_hit;

  always_comb begin
    pc_d   = pc;
    halt_d = halted;
    if (clear) begin
      pc_d   = '0;
      halt_d = 1'b0;
    end else begin
      if (step) begin
        pc_d = pc + 1'b1;
      end
      if (end_hit) begin
        halt_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      halted <= 1'b0;
    end else if (en) begin
      pc     <= pc_d;
      halted <= halt_d;
    end
  end

endmodule

// File: rtl/fa_seq_merge.sv
module fa_seq_merge #(
  parameter int CMD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_a,
  input  logic             issue_b,
  input  logic [CMD_W-1:0] pay_a,
  input  logic [CMD_W-1:0] pay_b,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_word
);
  logic             any_issue;
  logic [CMD_W-1:0] word_d;

  assign any_issue = issue_a || issue_b;
  assign word_d    = issue_a ? pay_a : pay_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
    end else begin
      cmd_valid <= any_issue;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_word <= '0;
    end else if (any_issue) begin
      cmd_word <= word_d;
    end
  end

endmodule

// File: rtl/fa_cmd_issuer.sv
module fa_cmd_issuer #(
  parameter int CMD_W   = 16,
  parameter int IMEM_AW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init_we,
  input  logic                 init_sel,
  input  logic [IMEM_AW-1:0]   init_addr,
  input  logic [CMD_W+1:0]     init_data,
  input  logic                 start,
  input  logic                 single_mode,
  input  logic                 dp_busy,
  output logic                 cmd_valid,
  output logic [CMD_W-1:0]     cmd_word,
  output logic                 done
);
  localparam int IW   = CMD_W + 2;
  localparam int NSEQ = 2;

  logic [1:0] rst_pipe;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign arst_n = rst_pipe[1];

  logic run_q, done_q, single_q, ph_q;
  logic run_d, done_d, single_d, ph_d;
  logic start_acc, stall_any, finish;

  logic [IMEM_AW-1:0] pc_w     [NSEQ];
  logic [IW-1:0]      instr_w  [NSEQ];
  logic               slot_w   [NSEQ];
  logic               issue_w  [NSEQ];
  logic               stall_w  [NSEQ];
  logic               end_w    [NSEQ];
  logic               halted_w [NSEQ];
  logic               fin_w    [NSEQ];

  assign start_acc = start && !run_q;
  assign slot_w[0] = run_q && !ph_q;
  assign slot_w[1] = run_q && ph_q && !single_q;

  for (genvar g = 0; g < NSEQ; g++) begin : g_seq
    logic mem_we;
    assign mem_we = init_we && !run_q && (init_sel == g[0]);

    fa_seq_imem #(.AW(IMEM_AW), .IW(IW)) u_imem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (init_addr),
      .wdata (init_data),
      .raddr (pc_w[g]),
      .rdata (instr_w[g])
    );

    fa_seq_engine #(.AW(IMEM_AW), .IW(IW)) u_eng (
      .clk     (clk),
      .rst_n   (arst_n),
      .clear   (start_acc),
      .slot    (slot_w[g]),
      .dp_busy (dp_busy),
      .instr   (instr_w[g]),
      .pc      (pc_w[g]),
      .halted  (halted_w[g]),
      .issue   (issue_w[g]),
      .stall   (stall_w[g]),
      .end_hit (end_w[g])
    );

    assign fin_w[g] = halted_w[g] || end_w[g];
  end

  assign stall_any = stall_w[0] || stall_w[1];
  assign finish    = run_q && fin_w[0] && (single_q || fin_w[1]);

  always_comb begin
    run_d    = run_q;
    done_d   = done_q;
    single_d = single_q;
    ph_d     = ph_q;
    if (start_acc) begin
      run_d    = 1'b1;
      done_d   = 1'b0;
      single_d = single_mode;
      ph_d     = 1'b0;
    end else if (run_q) begin
      if (!stall_any) begin
        ph_d = !ph_q;
      end
      if (finish) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      run_q    <= 1'b0;
      done_q   <= 1'b0;
      single_q <= 1'b0;
      ph_q     <= 1'b0;
    end else begin
      run_q    <= run_d;
      done_q   <= done_d;
      single_q <= single_d;
      ph_q     <= ph_d;
    end
  end

  fa_seq_merge #(.CMD_W(CMD_W)) u_merge (
    .clk       (clk),
    .rst_n     (arst_n),
    .issue_a   (issue_w[0]),
    .issue_b   (issue_w[1]),
    .pay_a     (instr_w[0][CMD_W-1:0]),
    .pay_b     (instr_w[1][CMD_W-1:0]),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word)
  );

  assign done = done_q;

endmodule

// File: rtl/fa_cmd_issuer_chk.sv
module fa_cmd_issuer_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic cmd_valid,
  input logic done,
  input logic run,
  input logic single,
  input logic stall,
  input logic phase
);

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);                                          // R5

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);                                    // R6

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !done);                                    // R6

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !cmd_valid);                                         // R4

  AST_STALL_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stall) |=> $stable(phase));                            // R4

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !stall) |=> (phase != $past(phase)));                  // R2

  AST_SINGLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (single && cmd_valid) |=> !cmd_valid);                         // R7

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start) |=> (single == $past(single)));                 // R8

endmodule

bind fa_cmd_issuer fa_cmd_issuer_chk u_chk (
  .clk       (clk),
  .rst_n     (arst_n),
  .start     (start),
  .cmd_valid (cmd_valid),
  .done      (done),
  .run       (run_q),
  .single    (single_q),
  .stall     (stall_any),
  .phase     (ph_q)
);

// File: tb/fa_cmd_issuer_test.sv
`timescale 1ns/1ps
module fa_cmd_issuer_test;
  localparam int CW = 16;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          init_we = 1'b0;
  logic          init_sel = 1'b0;
  logic [AW-1:0] init_addr = '0;
  logic [CW+1:0] init_data = '0;
  logic          start = 1'b0;
  logic          single_mode = 1'b0;
  logic          dp_busy = 1'b0;
  logic          cmd_valid;
  logic [CW-1:0] cmd_word;
  logic          done;

  always #2 clk = ~clk;

  fa_cmd_issuer #(.CMD_W(CW), .IMEM_AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .init_we(init_we), .init_sel(init_sel),
    .init_addr(init_addr), .init_data(init_data), .start(start),
    .single_mode(single_mode), .dp_busy(dp_busy), .cmd_valid(cmd_valid),
    .cmd_word(cmd_word), .done(done)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit chk_on = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference model: behavioural, advanced at each rising edge
  logic [CW+1:0] prog_a [DEPTH];
  logic [CW+1:0] prog_b [DEPTH];
  bit m_run = 0, m_done = 0, m_ph = 0, m_single = 0, m_ha = 0, m_hb = 0;
  int m_pa = 0, m_pb = 0;
  bit e_valid = 0;
  logic [CW-1:0] e_word = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_run = 0; m_done = 0; e_valid = 0; e_word = '0;
    end else begin
      bit v;
      v = 0;
      if (!m_run) begin
        if (init_we) begin
          if (init_sel) prog_b[init_addr] = init_data;
          else          prog_a[init_addr] = init_data;
        end
        if (start) begin
          m_run = 1; m_done = 0; m_ph = 0; m_pa = 0; m_pb = 0;
          m_ha = 0; m_hb = 0; m_single = single_mode;
        end
      end else begin
        bit use_a, use_b, halted, stalled;
        logic [CW+1:0] ins;
        use_a = !m_ph;
        use_b = m_ph && !m_single;
        stalled = 0;
        if (use_a || use_b) begin
          halted = use_a ? m_ha : m_hb;
          ins = use_a ? prog_a[m_pa] : prog_b[m_pb];
          if (!halted) begin
            if (ins[CW+1:CW] == 2'b01) begin
              if (dp_busy) stalled = 1;
              else if (use_a) m_pa = (m_pa + 1) % DEPTH;
              else m_pb = (m_pb + 1) % DEPTH;
            end else if (ins[CW+1:CW] == 2'b10) begin
              if (use_a) m_ha = 1; else m_hb = 1;
            end else begin
              v = 1;
              e_word = ins[CW-1:0];
              if (use_a) m_pa = (m_pa + 1) % DEPTH;
              else m_pb = (m_pb + 1) % DEPTH;
            end
          end
        end
        if (!stalled) m_ph = !m_ph;
        if (m_ha && (m_single || m_hb)) begin
          m_run = 0; m_done = 1;
        end
      end
      e_valid = v;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on) begin
      chk(cmd_valid == e_valid, "R2 cmd_valid", cmd_valid, e_valid);
      if (e_valid) chk(cmd_word == e_word, "R3 cmd_word", cmd_word, e_word);
      chk(done == m_done, "R5 done", done, m_done);
    end
  end

  // stream capture
  logic [CW-1:0] got [$];
  int            got_c [$];
  logic [CW-1:0] expq [$];
  always @(negedge clk) begin
    if (cmd_valid) begin
      got.push_back(cmd_word);
      got_c.push_back(cyc);
    end
  end

  function automatic logic [CW+1:0] ins(input logic [1:0] op, input logic [CW-1:0] pay);
    return {op, pay};
  endfunction

  task automatic load(input bit sel, input int addr, input logic [CW+1:0] word);
    @(negedge clk);
    init_we = 1'b1; init_sel = sel; init_addr = AW'(addr); init_data = word;
    @(negedge clk);
    init_we = 1'b0;
  endtask

  task automatic run_begin(input bit single, input string req);
    got.delete(); got_c.delete();
    @(negedge clk);
    single_mode = single; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cmd_valid == 1'b0, req, cmd_valid, 0);
    chk(done == 1'b0, "R6 cleared by start", done, 0);
    @(negedge clk);
    chk(cmd_valid == 1'b1, req, cmd_valid, 1);
  endtask

  task automatic run_wait();
    for (int i = 0; i < 400 && !done; i++) @(negedge clk);
    chk(done == 1'b1, "R5 run finished", done, 1);
  endtask

  task automatic cmp_stream(input string req);
    chk(got.size() == expq.size(), req, got.size(), expq.size());
    for (int i = 0; i < expq.size() && i < got.size(); i++)
      chk(got[i] == expq[i], req, got[i], expq[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_valid == 0 && done == 0, "R1 in reset", {cmd_valid, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd_valid == 0 && done == 0, "R1 after reset", {cmd_valid, done}, 0);
    chk_on = 1;

    // dual, equal-length issue programs
    for (int i = 0; i < 4; i++) begin
      load(0, i, ins(2'b00, 16'hA000 + 16'(i)));
      load(1, i, ins((i == 2) ? 2'b11 : 2'b00, 16'hB000 + 16'(i)));
    end
    load(0, 4, ins(2'b10, 0));
    load(1, 4, ins(2'b10, 0));
    run_begin(0, "R2 first command latency");
    run_wait();
    expq.delete();
    for (int i = 0; i < 4; i++) begin
      expq.push_back(16'hA000 + 16'(i));
      expq.push_back(16'hB000 + 16'(i));
    end
    cmp_stream("R3 interleaved order");
    for (int i = 1; i < got_c.size(); i++)
      chk(got_c[i] == got_c[i-1] + 1, "R2 back-to-back", got_c[i] - got_c[i-1], 1);

    // done held while idle
    repeat (10) @(negedge clk);
    chk(done == 1'b1, "R6 done held", done, 1);

    // wait instruction with datapath busy
    load(0, 0, ins(2'b00, 16'h1A00));
    load(0, 1, ins(2'b01, 0));
    load(0, 2, ins(2'b00, 16'h1A02));
    load(0, 3, ins(2'b10, 0));
    load(1, 0, ins(2'b00, 16'h1B00));
    load(1, 1, ins(2'b00, 16'h1B01));
    load(1, 2, ins(2'b10, 0));
    dp_busy = 1'b1;
    run_begin(0, "R2 latency with wait program");
    @(negedge clk);
    chk(cmd_valid == 1'b1, "R4 before stall", cmd_valid, 1);
    repeat (5) begin
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R4 stalled", cmd_valid, 0);
    end
    dp_busy = 1'b0;
    run_wait();
    expq.delete();
    expq.push_back(16'h1A00); expq.push_back(16'h1B00);
    expq.push_back(16'h1B01); expq.push_back(16'h1A02);
    cmp_stream("R4 order after wait");

    // unequal program lengths
    load(0, 0, ins(2'b00, 16'h00A0));
    load(0, 1, ins(2'b00, 16'h00A1));
    load(0, 2, ins(2'b10, 0));
    for (int i = 0; i < 4; i++) load(1, i, ins(2'b00, 16'h00B0 + 16'(i)));
    load(1, 4, ins(2'b10, 0));
    run_begin(0, "R2 latency unequal");
    run_wait();
    expq.delete();
    expq.push_back(16'h00A0); expq.push_back(16'h00B0);
    expq.push_back(16'h00A1); expq.push_back(16'h00B1);
    expq.push_back(16'h00B2); expq.push_back(16'h00B3);
    cmp_stream("R5 early stop order");
    chk(got_c.size() == 6 && got_c[5] - got_c[4] == 2, "R5 idle slot of stopped side",
        (got_c.size() == 6) ? got_c[5] - got_c[4] : -1, 2);

    // single mode, B holds unrelated commands
    load(0, 0, ins(2'b00, 16'h0C00));
    load(0, 1, ins(2'b00, 16'h0C01));
    load(0, 2, ins(2'b00, 16'h0C02));
    load(0, 3, ins(2'b10, 0));
    for (int i = 0; i < 6; i++) load(1, i, ins(2'b00, 16'hEEEE));
    run_begin(1, "R7 single latency");
    run_wait();
    expq.delete();
    expq.push_back(16'h0C00); expq.push_back(16'h0C01); expq.push_back(16'h0C02);
    cmp_stream("R7 only A executed");
    for (int i = 1; i < got_c.size(); i++)
      chk(got_c[i] == got_c[i-1] + 2, "R7 half rate", got_c[i] - got_c[i-1], 2);

    // start and init write during a run are ignored
    for (int i = 0; i < 6; i++) begin
      load(0, i, ins(2'b00, 16'hD000 + 16'(i)));
      load(1, i, ins(2'b00, 16'hE000 + 16'(i)));
    end
    load(0, 6, ins(2'b10, 0));
    load(1, 6, ins(2'b10, 0));
    run_begin(0, "R2 latency long");
    @(negedge clk);
    start = 1'b1; single_mode = 1'b1;
    @(negedge clk);
    start = 1'b0; single_mode = 1'b0;
    init_we = 1'b1; init_sel = 1'b0; init_addr = 5; init_data = ins(2'b00, 16'hFFFF);
    @(negedge clk);
    init_we = 1'b0;
    run_wait();
    expq.delete();
    for (int i = 0; i < 6; i++) begin
      expq.push_back(16'hD000 + 16'(i));
      expq.push_back(16'hE000 + 16'(i));
    end
    cmp_stream("R8 R9 stream unchanged");

    // write accepted while idle
    load(0, 5, ins(2'b00, 16'hFFFF));
    run_begin(0, "R2 latency rerun");
    run_wait();
    expq[10] = 16'hFFFF;
    cmp_stream("R9 idle write applied");

    chk_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule